// File: doc/BRIEF.md
# Latched Test Mode Output Selector

This block chooses how a clock generator's outputs behave: they either run normally, float in high impedance, or carry a divided-down reference clock. Test mode can be entered in two ways. The first is a dual-purpose strap pin, which is sampled once after power-on. The second is a control register bit, which applies only when the strap was captured low. Each way has its own rule for picking the test output. Once test mode is entered, only a power-on reset takes the block out of it.

The two control register bits and the mode pin are held in a register stage. The strap value and a sticky entry latch are kept apart from it. The resulting output mode is registered before it leaves the block, so the clock output stage sees a clean two-bit code and a test-active flag.

Top module: `tmode_sel`

## Requirements
- R1: The strap input is captured on the first clock edge at which `por_rst` is low, and `strap_valid` rises at that edge. Later changes on `strap_in` have no effect until the next power-on reset.
- R2: While `por_rst` is high, `out_mode` is 00, `test_active` is 0 and `strap_valid` is 0, and both held register bits are cleared to 0.
- R3: With the strap captured 0 and `cfg_test_en` at 0, `out_mode` is 00 (normal), whatever `mode_pin` and `cfg_ref_sel` are.
- R4: With the strap captured 1 and `mode_pin` at 1, `out_mode` is 10 (reference divided by N), whatever `cfg_ref_sel` is.
- R5: With the strap captured 1 and `mode_pin` at 0, `cfg_ref_sel` picks the output: 0 gives 01 (high impedance) and 1 gives 10.
- R6: With the strap captured 0, setting `cfg_test_en` enters test mode. `mode_pin` is then ignored, and `cfg_ref_sel` alone picks 01 (when 0) or 10 (when 1).
- R7: Once test mode is entered, `test_active` stays 1 and the output stays a test code (01 or 10), even if `cfg_test_en` is cleared, until `por_rst` is asserted.
- R8: `out_mode` takes only the codes 00 normal, 01 high impedance and 10 reference divided by N. It is non-zero exactly when `test_active` is 1.
- R9: A change on `cfg_test_en`, `cfg_ref_sel` or `mode_pin` shows on `out_mode` and `test_active` at the second rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| strap_in | input | 1 | Dual-purpose strap level, captured once |
| mode_pin | input | 1 | Test mode pin, used only on the strap entry path |
| cfg_test_en | input | 1 | Register bit that requests test entry |
| cfg_ref_sel | input | 1 | Register bit that selects the test output: 0 high-Z, 1 divided reference |
| out_mode | output | 2 | Output mode code: 00 normal, 01 high-Z, 10 divided reference |
| test_active | output | 1 | Sticky test-mode flag |
| strap_valid | output | 1 | Set once the strap has been captured |

## Verification
If the sticky latch lost its state, `test_active` would drop and `out_mode` would fall back to 00 at the edge after `cfg_test_en` is cleared. If the entry source were recorded wrongly, the fault would show when `mode_pin` toggles: on the register path `mode_pin` has no effect, but a wrong source would let it force code 10. A strap that is not held would let a later high level on `strap_in` raise `test_active` within two edges. In every case the fault appears at the ports no later than the second edge after the stimulus that exposes it.

// File: rtl/tmsel_pkg.sv
package tmsel_pkg;

    localparam int unsigned MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        OM_NORMAL = 2'b00,
        OM_HIZ    = 2'b01,
        OM_REFDIV = 2'b10
    } out_mode_e;

    typedef enum logic {
        SRC_STRAP = 1'b0,
        SRC_REG   = 1'b1
    } entry_src_e;

    typedef struct packed {
        logic test_en;
        logic ref_sel;
        logic mode_pin;
    } ctl_s;

    localparam ctl_s CTL_RESET = '{test_en: 1'b0, ref_sel: 1'b0, mode_pin: 1'b0};

    // Output rule for each entry path
    function automatic out_mode_e pick_mode(input logic active,
                                            input entry_src_e src,
                                            input ctl_s c);
        out_mode_e m;
        if (!active) begin
            m = OM_NORMAL;
        end else if (src == SRC_STRAP) begin
            m = (c.mode_pin || c.ref_sel) ? OM_REFDIV : OM_HIZ;
        end else begin
            m = c.ref_sel ? OM_REFDIV : OM_HIZ;
        end
        return m;
    endfunction

endpackage

// File: rtl/tmsel_strap.sv
module tmsel_strap (
    input  logic clk,
    input  logic por_rst,
    input  logic strap_in,
    output logic strap_q,
    output logic strap_valid
);
    // One-shot capture after power-on reset
    always_ff @(posedge clk) begin
        if (por_rst) begin
            strap_q     <= 1'b0;
            strap_valid <= 1'b0;
        end else if (!strap_valid) begin
            strap_q     <= strap_in;
            strap_valid <= 1'b1;
        end
    end
endmodule

// File: rtl/tmsel_ctl_hold.sv
module tmsel_ctl_hold
    import tmsel_pkg::*;
(
    input  logic clk,
    input  logic por_rst,
    input  logic cfg_test_en,
    input  logic cfg_ref_sel,
    input  logic mode_pin,
    output ctl_s ctl_q
);
    always_ff @(posedge clk) begin
        if (por_rst) begin
            ctl_q <= CTL_RESET;
        end else begin
            ctl_q.test_en  <= cfg_test_en;
            ctl_q.ref_sel  <= cfg_ref_sel;
            ctl_q.mode_pin <= mode_pin;
        end
    end
endmodule

// File: rtl/tmsel_latch.sv
module tmsel_latch
    import tmsel_pkg::*;
(
    input  logic       clk,
    input  logic       por_rst,
    input  logic       strap_valid,
    input  logic       strap_q,
    input  ctl_s       ctl_q,
    output logic       test_q,
    output entry_src_e src_q,
    output logic       test_nxt,
    output entry_src_e src_nxt
);
    logic entering;

    always_comb begin
        entering = strap_valid && (strap_q || ctl_q.test_en);
        test_nxt = test_q || entering;
        if (test_q) begin
            src_nxt = src_q;
        end else begin
            src_nxt = strap_q ? SRC_STRAP : SRC_REG;
        end
    end

    // Sticky: only power-on reset clears it
    always_ff @(posedge clk) begin
        if (por_rst) begin
            test_q <= 1'b0;
            src_q  <= SRC_STRAP;
        end else begin
            test_q <= test_nxt;
            src_q  <= src_nxt;
        end
    end
endmodule

// File: rtl/tmode_sel.sv
module tmode_sel
    import tmsel_pkg::*;
(
    input  logic              clk,
    input  logic              por_rst,
    input  logic              strap_in,
    input  logic              mode_pin,
    input  logic              cfg_test_en,
    input  logic              cfg_ref_sel,
    output logic [MODE_W-1:0] out_mode,
    output logic              test_active,
    output logic              strap_valid
);
    logic       strap_q;
    ctl_s       ctl_q;
    logic       test_q;
    logic       test_nxt;
    entry_src_e src_q;
    entry_src_e src_nxt;
    out_mode_e  mode_q;

    tmsel_strap u_strap (
        .clk         (clk),
        .por_rst     (por_rst),
        .strap_in    (strap_in),
        .strap_q     (strap_q),
        .strap_valid (strap_valid)
    );

    tmsel_ctl_hold u_ctl (
        .clk         (clk),
        .por_rst     (por_rst),
        .cfg_test_en (cfg_test_en),
        .cfg_ref_sel (cfg_ref_sel),
        .mode_pin    (mode_pin),
        .ctl_q       (ctl_q)
    );

    tmsel_latch u_latch (
        .clk         (clk),
        .por_rst     (por_rst),
        .strap_valid (strap_valid),
        .strap_q     (strap_q),
        .ctl_q       (ctl_q),
        .test_q      (test_q),
        .src_q       (src_q),
        .test_nxt    (test_nxt),
        .src_nxt     (src_nxt)
    );

    // Output code registered on the same edge as the latch
    always_ff @(posedge clk) begin
        if (por_rst) begin
            mode_q <= OM_NORMAL;
        end else begin
            mode_q <= pick_mode(test_nxt, src_nxt, ctl_q);
        end
    end

    assign out_mode    = mode_q;
    assign test_active = test_q;
endmodule

// File: rtl/tmode_sel_chk.sv
module tmode_sel_chk (
    input logic       clk,
    input logic       por_rst,
    input logic [1:0] out_mode,
    input logic       test_active,
    input logic       strap_valid
);
    // R2
    reset_state_chk: assert property (@(posedge clk)
        por_rst |=> (out_mode == 2'b00 && !test_active && !strap_valid));

    // R8
    legal_code_chk: assert property (@(posedge clk) disable iff (por_rst)
        out_mode != 2'b11);

    // R8
    code_flag_match_chk: assert property (@(posedge clk) disable iff (por_rst)
        (out_mode != 2'b00) == test_active);

    // R7
    sticky_test_chk: assert property (@(posedge clk) disable iff (por_rst)
        test_active |=> test_active);

    // R1
    strap_once_chk: assert property (@(posedge clk) disable iff (por_rst)
        strap_valid |=> strap_valid);

    // R1
    no_test_before_strap_chk: assert property (@(posedge clk) disable iff (por_rst)
        !strap_valid |-> !test_active);
endmodule

bind tmode_sel tmode_sel_chk chk_i (
    .clk         (clk),
    .por_rst     (por_rst),
    .out_mode    (out_mode),
    .test_active (test_active),
    .strap_valid (strap_valid)
);

// File: tb/tmode_sel_tb.sv
module tmode_sel_tb_top;
    logic       clk = 1'b0;
    logic       por_rst = 1'b1;
    logic       strap_in = 1'b0;
    logic       mode_pin = 1'b0;
    logic       cfg_test_en = 1'b0;
    logic       cfg_ref_sel = 1'b0;
    logic [1:0] out_mode;
    logic       test_active;
    logic       strap_valid;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    tmode_sel dut_i (
        .clk         (clk),
        .por_rst     (por_rst),
        .strap_in    (strap_in),
        .mode_pin    (mode_pin),
        .cfg_test_en (cfg_test_en),
        .cfg_ref_sel (cfg_ref_sel),
        .out_mode    (out_mode),
        .test_active (test_active),
        .strap_valid (strap_valid)
    );

    // {strap, mode_pin, bit6, bit7, expected code[1:0], expected flag}
    localparam logic [6:0] VEC [9] = '{
        7'b0000_00_0,  // R3
        7'b0101_00_0,  // R3 mode pin and bit7 ignored
        7'b1000_01_1,  // R5 high-Z
        7'b1001_10_1,  // R5 divided reference
        7'b1100_10_1,  // R4
        7'b1111_10_1,  // R4
        7'b0010_01_1,  // R6 high-Z
        7'b0110_01_1,  // R6 mode pin ignored
        7'b0111_10_1   // R6 divided reference
    };

    task automatic check(input string req, input logic [1:0] exp_m, input logic exp_t);
        total++;
        if (out_mode !== exp_m || test_active !== exp_t) begin
            bad++;
            $display("FAIL %s: mode=%b test=%b expected mode=%b test=%b",
                     req, out_mode, test_active, exp_m, exp_t);
        end
    endtask

    task automatic power_up(input logic s);
        @(negedge clk);
        por_rst = 1'b1;
        strap_in = s;
        mode_pin = 1'b0;
        cfg_test_en = 1'b0;
        cfg_ref_sel = 1'b0;
        repeat (2) @(negedge clk);
        por_rst = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        // R2 reset state
        repeat (3) @(negedge clk);
        check("R2", 2'b00, 1'b0);
        total++;
        if (strap_valid !== 1'b0) begin
            bad++;
            $display("FAIL R2: strap_valid=%b expected 0", strap_valid);
        end

        foreach (VEC[i]) begin
            power_up(VEC[i][6]);
            mode_pin    = VEC[i][5];
            cfg_test_en = VEC[i][4];
            cfg_ref_sel = VEC[i][3];
            wait_edges(3);
            check($sformatf("R3-6 vec%0d", i), VEC[i][2:1], VEC[i][0]);
        end

        // R1: capture at first edge, later strap ignored
        power_up(1'b0);
        wait_edges(1);
        total++;
        if (strap_valid !== 1'b1) begin
            bad++;
            $display("FAIL R1: strap_valid=%b expected 1", strap_valid);
        end
        strap_in = 1'b1;
        mode_pin = 1'b1;
        wait_edges(4);
        check("R1 late strap", 2'b00, 1'b0);

        // R7 sticky after register entry, R9 latency
        power_up(1'b0);
        cfg_test_en = 1'b1;
        cfg_ref_sel = 1'b1;
        wait_edges(3);
        check("R6 reg entry", 2'b10, 1'b1);
        cfg_test_en = 1'b0;
        wait_edges(3);
        check("R7 bit6 cleared", 2'b10, 1'b1);
        cfg_ref_sel = 1'b0;
        wait_edges(1);
        check("R9 one edge", 2'b10, 1'b1);
        wait_edges(1);
        check("R9 two edges", 2'b01, 1'b1);
        mode_pin = 1'b1;
        wait_edges(3);
        check("R6 mode pin after entry", 2'b01, 1'b1);

        // R9 entry latency from register bit
        power_up(1'b0);
        wait_edges(2);
        cfg_test_en = 1'b1;
        wait_edges(1);
        check("R9 entry one edge", 2'b00, 1'b0);
        wait_edges(1);
        check("R9 entry two edges", 2'b01, 1'b1);

        // R7 only reset leaves; strap path, then mode pin toggling
        power_up(1'b1);
        wait_edges(3);
        check("R5 strap high-Z", 2'b01, 1'b1);
        mode_pin = 1'b1;
        wait_edges(2);
        check("R4 strap pin", 2'b10, 1'b1);
        @(negedge clk);
        por_rst = 1'b1;
        wait_edges(1);
        check("R7 reset exits", 2'b00, 1'b0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule